// File: doc/BRIEF.md
# Synthesizer Control Register Slave on a Two-Wire Bus

This block is the serial control front end of a frequency synthesizer. It listens on a two-wire bus (SCL clock, SDA data) and samples both lines with its own system clock. It pulls SDA low through an open-drain style output. A master writes a burst that starts with a sub-address byte and continues with data bytes. Each data byte lands in one of four 8-bit control registers, named A, B, C and D, which drive the synthesizer directly.

The sub-address byte has two jobs. It selects the first register of the burst. It also sets two flags. The first flag decides whether the register pointer moves forward after each data byte. The second flag is an alarm-disable bit, which the block holds on an output.

One bit of the device address comes from a strap pin. This lets two devices share a bus. A read transaction returns a status byte that the block takes from an input port.

Top module: `synth_i2c_regbank`

## Requirements
- R1: The address byte, MSB first, must be 1,1,0,0,0,1, then the inverse of `strap_i`, then R/W. On a match the block pulls SDA low for the ninth (ACK) clock.
- R2: If the address does not match, the block never pulls SDA low, and the registers and the alarm-disable flag stay unchanged until the next START.
- R3: In the sub-address byte, bit 4 is the alarm-disable flag and bit 3 is the auto-increment enable. The other upper bits are ignored. The flag is latched to `alarm_dis_o` when the sub-address byte completes.
- R4: Bits 1:0 of the sub-address byte select the register for the first data byte: 00 is A, 01 is B, 10 is C and 11 is D.
- R5: With auto-increment on, each data byte advances the pointer by one, and the pointer wraps from D back to A.
- R6: With auto-increment off, every data byte of the burst is written to the same register.
- R7: The block ACKs the matched address, the sub-address and every data byte, including bytes after the fourth. It only starts pulling SDA low after a falling edge of SCL.
- R8: A read returns `status_i` MSB first, one bit per SCL clock. The block reloads `status_i` after each master ACK. After a master NACK it releases SDA.
- R9: A register or the flag changes only when the eighth bit of a byte is received. A burst cut short by a repeated START or a STOP leaves a partly received byte unwritten.
- R10: After reset, all four registers and `alarm_dis_o` are 0 and SDA is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to sample the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| sda_pull_o | output | 1 | 1 = pull SDA low (open-drain drive) |
| strap_i | input | 1 | Address strap; the address bit is its inverse |
| status_i | input | 8 | Byte returned on a read |
| reg_a_o | output | 8 | Control register A |
| reg_b_o | output | 8 | Control register B |
| reg_c_o | output | 8 | Control register C |
| reg_d_o | output | 8 | Control register D |
| alarm_dis_o | output | 1 | Latched alarm-disable flag |

## Verification
The assertions assume that SCL is slow compared to `clk`, and that SDA changes only while SCL is low, except at START and STOP. This means the synchronized SCL edge always comes before any data change that belongs to it. The bench holds each SCL phase for eight system clocks. It moves SDA two clocks after SCL falls and releases its own drive whenever the slave is expected to drive. As a result, no false START or STOP appears, and the slave's ACK and read-data drive always change while SCL is low.

// File: rtl/synth_i2c_pkg.sv
package synth_i2c_pkg;
    localparam int          BYTE_W      = 8;
    localparam logic [5:0]  DEV_ADDR_HI = 6'b110001;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_SUB,
        ST_SUB_ACK,
        ST_DATA,
        ST_DATA_ACK,
        ST_TX,
        ST_TX_ACK,
        ST_IGNORE
    } ctrl_state_e;
endpackage

// File: rtl/i2c_line_watch.sv
module i2c_line_watch (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_ev,
    output logic stop_ev
);
    typedef struct packed {
        logic [1:0] scl_sync;
        logic [1:0] sda_sync;
        logic       scl_prev;
        logic       sda_prev;
    } watch_t;

    watch_t w_d, w_q;

    always_comb begin
        w_d          = w_q;
        w_d.scl_sync = {w_q.scl_sync[0], scl_i};
        w_d.sda_sync = {w_q.sda_sync[0], sda_i};
        w_d.scl_prev = w_q.scl_sync[1];
        w_d.sda_prev = w_q.sda_sync[1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) w_q <= '1;
        else        w_q <= w_d;
    end

    assign scl_s    = w_q.scl_sync[1];
    assign sda_s    = w_q.sda_sync[1];
    assign scl_rise = scl_s & ~w_q.scl_prev;
    assign scl_fall = ~scl_s & w_q.scl_prev;
    assign start_ev = scl_s & w_q.scl_prev & w_q.sda_prev & ~sda_s;
    assign stop_ev  = scl_s & w_q.scl_prev & ~w_q.sda_prev & sda_s;
endmodule

// File: rtl/i2c_slave_ctrl.sv
module i2c_slave_ctrl
    import synth_i2c_pkg::*;
#(
    parameter int N_REGS  = 4,
    parameter int AVI_BIT = 3,
    parameter int DI_BIT  = 4,
    localparam int PTR_W  = $clog2(N_REGS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sda_s,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              start_ev,
    input  logic              stop_ev,
    input  logic              strap_i,
    input  logic [BYTE_W-1:0] status_i,
    output logic              sda_pull_o,
    output logic              alarm_dis_o,
    output logic              wr_en_o,
    output logic [PTR_W-1:0]  wr_idx_o,
    output logic [BYTE_W-1:0] wr_data_o
);
    typedef struct packed {
        ctrl_state_e       state;
        logic [3:0]        cnt;
        logic [BYTE_W-1:0] sh;
        logic              pull;
        logic [PTR_W-1:0]  ptr;
        logic              avi;
        logic              di;
        logic              ack_seen;
        logic              wr_en;
        logic [PTR_W-1:0]  wr_idx;
        logic [BYTE_W-1:0] wr_data;
    } ctrl_t;

    ctrl_t c_d, c_q;
    logic [BYTE_W-1:0] rx_byte;
    logic              addr_hit;

    always_comb begin
        c_d       = c_q;
        c_d.wr_en = 1'b0;
        rx_byte   = {c_q.sh[BYTE_W-2:0], sda_s};
        addr_hit  = (c_q.sh[BYTE_W-1:1] == {DEV_ADDR_HI, ~strap_i});
        if (start_ev) begin
            c_d.state = ST_ADDR;
            c_d.cnt   = '0;
            c_d.pull  = 1'b0;
        end else if (stop_ev) begin
            c_d.state = ST_IDLE;
            c_d.cnt   = '0;
            c_d.pull  = 1'b0;
        end else begin
            case (c_q.state)
                ST_ADDR: begin
                    if (scl_rise) begin
                        c_d.sh  = rx_byte;
                        c_d.cnt = c_q.cnt + 4'd1;
                    end else if (scl_fall && c_q.cnt == 4'd8) begin
                        c_d.cnt = '0;
                        if (addr_hit) begin
                            c_d.pull  = 1'b1;
                            c_d.state = ST_ADDR_ACK;
                        end else begin
                            c_d.state = ST_IGNORE;
                        end
                    end
                end
                ST_ADDR_ACK: begin
                    if (scl_fall) begin
                        c_d.cnt = '0;
                        if (c_q.sh[0]) begin
                            c_d.state = ST_TX;
                            c_d.pull  = ~status_i[BYTE_W-1];
                            c_d.sh    = {status_i[BYTE_W-2:0], 1'b0};
                        end else begin
                            c_d.state = ST_SUB;
                            c_d.pull  = 1'b0;
                        end
                    end
                end
                ST_SUB: begin
                    if (scl_rise) begin
                        c_d.sh  = rx_byte;
                        c_d.cnt = c_q.cnt + 4'd1;
                        if (c_q.cnt == 4'd7) begin
                            c_d.ptr = rx_byte[PTR_W-1:0];
                            c_d.avi = rx_byte[AVI_BIT];
                            c_d.di  = rx_byte[DI_BIT];
                        end
                    end else if (scl_fall && c_q.cnt == 4'd8) begin
                        c_d.cnt   = '0;
                        c_d.pull  = 1'b1;
                        c_d.state = ST_SUB_ACK;
                    end
                end
                ST_SUB_ACK, ST_DATA_ACK: begin
                    if (scl_fall) begin
                        c_d.pull  = 1'b0;
                        c_d.cnt   = '0;
                        c_d.state = ST_DATA;
                    end
                end
                ST_DATA: begin
                    if (scl_rise) begin
                        c_d.sh  = rx_byte;
                        c_d.cnt = c_q.cnt + 4'd1;
                        if (c_q.cnt == 4'd7) begin
                            c_d.wr_en   = 1'b1;
                            c_d.wr_idx  = c_q.ptr;
                            c_d.wr_data = rx_byte;
                            if (c_q.avi) c_d.ptr = c_q.ptr + 1'b1;
                        end
                    end else if (scl_fall && c_q.cnt == 4'd8) begin
                        c_d.cnt   = '0;
                        c_d.pull  = 1'b1;
                        c_d.state = ST_DATA_ACK;
                    end
                end
                ST_TX: begin
                    if (scl_rise) begin
                        c_d.cnt = c_q.cnt + 4'd1;
                    end else if (scl_fall) begin
                        if (c_q.cnt == 4'd8) begin
                            c_d.pull  = 1'b0;
                            c_d.cnt   = '0;
                            c_d.state = ST_TX_ACK;
                        end else begin
                            c_d.pull = ~c_q.sh[BYTE_W-1];
                            c_d.sh   = {c_q.sh[BYTE_W-2:0], 1'b0};
                        end
                    end
                end
                ST_TX_ACK: begin
                    if (scl_rise) begin
                        c_d.ack_seen = ~sda_s;
                    end else if (scl_fall) begin
                        c_d.cnt = '0;
                        if (c_q.ack_seen) begin
                            c_d.state = ST_TX;
                            c_d.pull  = ~status_i[BYTE_W-1];
                            c_d.sh    = {status_i[BYTE_W-2:0], 1'b0};
                        end else begin
                            c_d.state = ST_IGNORE;
                            c_d.pull  = 1'b0;
                        end
                    end
                end
                default: begin
                    c_d.pull = 1'b0;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c_q       <= '0;
            c_q.state <= ST_IDLE;
        end else begin
            c_q <= c_d;
        end
    end

    assign sda_pull_o  = c_q.pull;
    assign alarm_dis_o = c_q.di;
    assign wr_en_o     = c_q.wr_en;
    assign wr_idx_o    = c_q.wr_idx;
    assign wr_data_o   = c_q.wr_data;

    // R2: an unmatched or finished transfer never pulls the line
    a_r2_silent_when_ignoring: assert property (@(posedge clk) disable iff (!rst_n)
        (c_q.state == ST_IGNORE) |-> !c_q.pull);

    // R7: the drive is only switched on after an SCL falling edge
    a_r7_pull_after_scl_fall: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(c_q.pull) |-> $past(scl_fall));

    // R5: with auto-increment a write moves the pointer on by one (wrapping)
    a_r5_ptr_advances: assert property (@(posedge clk) disable iff (!rst_n)
        (c_q.wr_en && c_q.avi) |-> (c_q.ptr == PTR_W'($past(c_q.ptr) + 1'b1)));

    // R6: without auto-increment a write leaves the pointer where it was
    a_r6_ptr_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (c_q.wr_en && !c_q.avi) |-> (c_q.ptr == $past(c_q.ptr)));

    // R3: the alarm-disable flag only moves while a sub-address byte is received
    a_r3_flag_from_subaddr: assert property (@(posedge clk) disable iff (!rst_n)
        (c_q.di != $past(c_q.di)) |-> ($past(c_q.state) == ST_SUB));
endmodule

// File: rtl/i2c_ctl_regs.sv
module i2c_ctl_regs #(
    parameter int N_REGS = 4,
    parameter int W      = 8,
    localparam int PTR_W = $clog2(N_REGS)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr_en,
    input  logic [PTR_W-1:0]       wr_idx,
    input  logic [W-1:0]           wr_data,
    output logic [N_REGS-1:0][W-1:0] regs_o
);
    logic [N_REGS-1:0][W-1:0] regs_d, regs_q;

    always_comb begin
        regs_d = regs_q;
        if (wr_en) regs_d[wr_idx] = wr_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) regs_q <= '0;
        else        regs_q <= regs_d;
    end

    assign regs_o = regs_q;

    for (genvar gi = 0; gi < N_REGS; gi++) begin : g_hold
        // R9: a register changes only after a write aimed at it
        a_r9_hold_without_write: assert property (@(posedge clk) disable iff (!rst_n)
            !(wr_en && wr_idx == PTR_W'(gi)) |=> (regs_q[gi] == $past(regs_q[gi])));
    end
endmodule

// File: rtl/synth_i2c_regbank.sv
module synth_i2c_regbank
    import synth_i2c_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_i,
    input  logic       sda_i,
    output logic       sda_pull_o,
    input  logic       strap_i,
    input  logic [7:0] status_i,
    output logic [7:0] reg_a_o,
    output logic [7:0] reg_b_o,
    output logic [7:0] reg_c_o,
    output logic [7:0] reg_d_o,
    output logic       alarm_dis_o
);
    localparam int N_REGS = 4;
    localparam int PTR_W  = $clog2(N_REGS);

    logic scl_s, sda_s, scl_rise, scl_fall, start_ev, stop_ev;
    logic                     wr_en;
    logic [PTR_W-1:0]         wr_idx;
    logic [BYTE_W-1:0]        wr_data;
    logic [N_REGS-1:0][BYTE_W-1:0] regs;

    i2c_line_watch u_watch (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_i    (scl_i),
        .sda_i    (sda_i),
        .scl_s    (scl_s),
        .sda_s    (sda_s),
        .scl_rise (scl_rise),
        .scl_fall (scl_fall),
        .start_ev (start_ev),
        .stop_ev  (stop_ev)
    );

    i2c_slave_ctrl #(.N_REGS(N_REGS)) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .sda_s       (sda_s),
        .scl_rise    (scl_rise),
        .scl_fall    (scl_fall),
        .start_ev    (start_ev),
        .stop_ev     (stop_ev),
        .strap_i     (strap_i),
        .status_i    (status_i),
        .sda_pull_o  (sda_pull_o),
        .alarm_dis_o (alarm_dis_o),
        .wr_en_o     (wr_en),
        .wr_idx_o    (wr_idx),
        .wr_data_o   (wr_data)
    );

    i2c_ctl_regs #(.N_REGS(N_REGS), .W(BYTE_W)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_idx  (wr_idx),
        .wr_data (wr_data),
        .regs_o  (regs)
    );

    assign reg_a_o = regs[0];
    assign reg_b_o = regs[1];
    assign reg_c_o = regs[2];
    assign reg_d_o = regs[3];

    // R8: scl_s is unused beyond edge detection here
    logic unused_scl;
    assign unused_scl = scl_s;
endmodule

// File: tb/synth_i2c_regbank_bench.sv
module synth_i2c_regbank_bench;
    localparam int CLK_PERIOD = 10;
    localparam int HALF       = 8;
    localparam int WATCHDOG   = 100000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl_m = 1'b1;
    logic       sda_m = 1'b1;
    logic       strap = 1'b0;
    logic [7:0] status = 8'h00;
    logic       sda_pull;
    logic [7:0] ra, rb, rc, rd;
    logic       adis;
    logic       sda_line;

    int n_checks = 0, n_errors = 0;
    int c_checks = 0, c_errors = 0;
    bit finished = 1'b0;

    int   exp_reg [4];
    logic exp_di;
    int   m_ptr;
    bit   m_avi;

    always #(CLK_PERIOD/2) clk = ~clk;
    assign sda_line = sda_m & ~sda_pull;

    synth_i2c_regbank u_synth_i2c_regbank (
        .clk         (clk),
        .rst_n       (rst_n),
        .scl_i       (scl_m),
        .sda_i       (sda_line),
        .sda_pull_o  (sda_pull),
        .strap_i     (strap),
        .status_i    (status),
        .reg_a_o     (ra),
        .reg_b_o     (rb),
        .reg_c_o     (rc),
        .reg_d_o     (rd),
        .alarm_dis_o (adis)
    );

    // Reference model compared on every settled clock (R4, R5, R6, R9, R3)
    int   settle = 8;
    logic p_scl = 1'b1, p_sda = 1'b1;
    always @(negedge clk) begin
        if (scl_m !== p_scl || sda_m !== p_sda || !rst_n) settle = 6;
        else if (settle > 0) settle--;
        p_scl = scl_m;
        p_sda = sda_m;
        if (settle == 0 && !finished) begin
            c_checks++;
            if (ra !== 8'(exp_reg[0]) || rb !== 8'(exp_reg[1]) ||
                rc !== 8'(exp_reg[2]) || rd !== 8'(exp_reg[3]) || adis !== exp_di) begin
                c_errors++;
                $display("FAIL R9 model: regs %h %h %h %h di %b expected %h %h %h %h di %b",
                         ra, rb, rc, rd, adis, exp_reg[0][7:0], exp_reg[1][7:0],
                         exp_reg[2][7:0], exp_reg[3][7:0], exp_di);
            end
        end
    end

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // kind 0: no model effect, 1: sub-address byte, 2: data byte
    task automatic model_apply(input int kind, input logic [7:0] b);
        if (kind == 1) begin
            m_ptr  = int'(b[1:0]);
            m_avi  = b[3];
            exp_di = b[4];
        end else if (kind == 2) begin
            exp_reg[m_ptr] = int'(b);
            if (m_avi) m_ptr = (m_ptr + 1) % 4;
        end
    endtask

    task automatic bus_start();
        wait_clk(2);
        sda_m = 1'b1;
        wait_clk(HALF);
        scl_m = 1'b1;
        wait_clk(HALF);
        sda_m = 1'b0;
        wait_clk(HALF);
        scl_m = 1'b0;
    endtask

    task automatic bus_stop();
        wait_clk(2);
        sda_m = 1'b0;
        wait_clk(HALF);
        scl_m = 1'b1;
        wait_clk(HALF);
        sda_m = 1'b1;
        wait_clk(HALF);
    endtask

    task automatic send_bit(input logic b);
        wait_clk(2);
        sda_m = b;
        wait_clk(HALF - 2);
        scl_m = 1'b1;
        wait_clk(HALF);
        scl_m = 1'b0;
    endtask

    task automatic send_byte(input logic [7:0] b, input int kind, input bit exp_ack, input string req);
        for (int i = 7; i >= 0; i--) begin
            wait_clk(2);
            sda_m = b[i];
            wait_clk(HALF - 2);
            scl_m = 1'b1;
            if (i == 0) model_apply(kind, b);
            wait_clk(HALF);
            scl_m = 1'b0;
        end
        wait_clk(2);
        sda_m = 1'b1;
        wait_clk(HALF - 2);
        scl_m = 1'b1;
        wait_clk(HALF / 2);
        check((sda_line == 1'b0) == exp_ack, req, int'(!sda_line), int'(exp_ack));
        wait_clk(HALF / 2);
        scl_m = 1'b0;
    endtask

    task automatic read_byte(input logic [7:0] exp, input bit master_ack, input logic [7:0] next_status);
        logic [7:0] got;
        got = '0;
        wait_clk(2);
        sda_m = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            wait_clk(HALF - 2);
            scl_m = 1'b1;
            wait_clk(HALF / 2);
            got[i] = sda_line;
            wait_clk(HALF / 2);
            scl_m = 1'b0;
            wait_clk(2);
        end
        check(got == exp, "R8 read byte", int'(got), int'(exp));
        status = next_status;
        sda_m = master_ack ? 1'b0 : 1'b1;
        wait_clk(HALF - 2);
        scl_m = 1'b1;
        wait_clk(HALF / 2);
        check(sda_pull == 1'b0, "R8 released for master ack", int'(sda_pull), 0);
        wait_clk(HALF / 2);
        scl_m = 1'b0;
    endtask

    initial begin
        for (int i = 0; i < 4; i++) exp_reg[i] = 0;
        exp_di = 1'b0;
        m_ptr  = 0;
        m_avi  = 1'b0;
        wait_clk(5);
        // R10: reset state
        check(ra == 0 && rb == 0 && rc == 0 && rd == 0, "R10 regs after reset",
              int'({ra, rb, rc, rd}), 0);
        check(adis == 1'b0 && sda_pull == 1'b0, "R10 flag and SDA after reset",
              int'({adis, sda_pull}), 0);
        rst_n = 1'b1;
        wait_clk(10);

        // R4, R5: auto-increment from A fills A..D; strap low so address bit = 1
        bus_start();
        send_byte(8'hC6, 0, 1'b1, "R1 address ack strap low");
        send_byte(8'h08, 1, 1'b1, "R7 sub-address ack");
        send_byte(8'h11, 2, 1'b1, "R4 data to A ack");
        send_byte(8'h22, 2, 1'b1, "R5 data to B ack");
        send_byte(8'h33, 2, 1'b1, "R5 data to C ack");
        send_byte(8'h44, 2, 1'b1, "R5 data to D ack");
        bus_stop();
        check(ra == 8'h11 && rd == 8'h44, "R4 R5 A and D after burst", int'({ra, rd}), 16'h1144);

        // R5, R7: start at C, wrap D->A, fifth byte still acked
        bus_start();
        send_byte(8'hC6, 0, 1'b1, "R1 address ack");
        send_byte(8'hEA, 1, 1'b1, "R3 sub-address with unused bits set");
        send_byte(8'h55, 2, 1'b1, "R7 byte 1");
        send_byte(8'h66, 2, 1'b1, "R7 byte 2");
        send_byte(8'h77, 2, 1'b1, "R7 byte 3");
        send_byte(8'h88, 2, 1'b1, "R7 byte 4");
        send_byte(8'h99, 2, 1'b1, "R7 byte 5 beyond fourth");
        bus_stop();
        check(rc == 8'h99 && ra == 8'h77, "R5 wrap result", int'({rc, ra}), 16'h9977);

        // R6, R3: no auto-increment, pointer B, alarm disabled
        bus_start();
        send_byte(8'hC6, 0, 1'b1, "R1 address ack");
        send_byte(8'h11, 1, 1'b1, "R3 sub-address ack");
        send_byte(8'hAA, 2, 1'b1, "R6 byte 1");
        send_byte(8'hBB, 2, 1'b1, "R6 byte 2");
        send_byte(8'hCC, 2, 1'b1, "R6 byte 3");
        bus_stop();
        check(rb == 8'hCC && adis == 1'b1, "R6 R3 B holds last, flag set", int'({rb, 7'b0, adis}), 16'hCC01);

        // R2: address with wrong strap bit is ignored
        bus_start();
        send_byte(8'hC4, 0, 1'b0, "R2 no ack on mismatch");
        send_byte(8'h00, 0, 1'b0, "R2 sub-address ignored");
        send_byte(8'h5A, 0, 1'b0, "R2 data ignored");
        bus_stop();
        check(adis == 1'b1 && ra == 8'h77, "R2 state unchanged", int'({ra, 7'b0, adis}), 16'h7701);

        // R1: strap high means address bit 0
        strap = 1'b1;
        wait_clk(4);
        bus_start();
        send_byte(8'hC6, 0, 1'b0, "R1 old address now rejected");
        bus_start();
        send_byte(8'hC4, 0, 1'b1, "R1 address ack strap high");
        send_byte(8'h03, 1, 1'b1, "R4 sub-address pointer D");
        send_byte(8'h5A, 2, 1'b1, "R4 data to D");
        bus_stop();
        check(rd == 8'h5A && adis == 1'b0, "R4 D written, R3 flag cleared", int'({rd, 7'b0, adis}), 16'h5A00);

        // R9: partial byte cut by repeated START is not written
        bus_start();
        send_byte(8'hC4, 0, 1'b1, "R1 address ack");
        send_byte(8'h08, 1, 1'b1, "R7 sub-address ack");
        for (int i = 0; i < 5; i++) send_bit(1'b0);
        bus_start();
        bus_stop();
        check(ra == 8'h77, "R9 A untouched by partial byte", int'(ra), 16'h77);

        // R8: read status, master ACKs once then NACKs
        status = 8'hA5;
        bus_start();
        send_byte(8'hC5, 0, 1'b1, "R1 read address ack");
        read_byte(8'hA5, 1'b1, 8'h3C);
        read_byte(8'h3C, 1'b0, 8'h3C);
        wait_clk(4);
        check(sda_pull == 1'b0, "R8 SDA released after NACK", int'(sda_pull), 0);
        bus_stop();
        wait_clk(10);

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors",
                 n_checks + c_checks, n_errors + c_errors);
        $finish;
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors",
                     n_checks + c_checks + 1, n_errors + c_errors + 1);
            $finish;
        end
    end
endmodule